// File: doc/BRIEF.md
# Sampler Serial Control Sequencer

This block drives the serial control pins of a switched-capacitor waveform sampler from the FPGA side. It has five commands. It can shift an 8-bit configuration word or an 8-bit write-pattern word into the sampler, and it can load both with the preset used for channel chaining. It can run a region-of-interest readout that pulses the read-shift load strobe, fetches the 10-bit stop cell and then steps through every sample cell. It can also read back the single write-pattern state bit. Each command is one pulse on `cmd_valid` together with an opcode.

A serial transfer has one rising and one falling edge of `sr_clk`, and the sampler takes data on the falling edge. The sequencer changes `sr_in` one system clock after each falling edge. It samples `sr_out` on that same clock. In the cell phase, each falling edge hands a physical cell index to the ADC capture stage on `cell_idx` and `cell_strobe`. The index starts at the stop cell and wraps around the ring. While the sampler is recording (`sampling` high), every serial pin is frozen, and the sequence resumes where it stopped once `sampling` falls.

Top module: `smp_ser_seq`

## Requirements
- R1: After reset, `sr_clk`, `busy`, `rd_load`, `sr_in` and all strobes are low, and `sr_addr` is 4'b0000.
- R2: Opcode 3'd1 shifts `cmd_data` into the configuration register at address 4'b1100, MSB first, with exactly 8 falling `sr_clk` edges. `sr_in` is stable across each falling edge.
- R3: Opcode 3'd2 shifts `cmd_data` into the write-pattern register at address 4'b1101, MSB first, with exactly 8 falling edges.
- R4: Opcode 3'd3 first loads 8'hFF into the configuration register at 4'b1100 and then loads 8'h55 into the write-pattern register at 4'b1101, with 16 falling edges in total.
- R5: Opcode 3'd4 sets address 4'b1011 and pulses `rd_load` while `sr_clk` is low. It then gives 10 falling edges. The sampler presents the stop cell MSB first, one new bit after each falling edge, and `sr_out` is captured one system clock after that edge. At the end, `stop_pos` holds the value and `stop_valid` pulses once.
- R6: After the stop fetch, the readout gives 1024 more falling edges. The n-th of these (n = 0..1023) produces one `cell_strobe` with `cell_idx` equal to (stop + n) mod 1024.
- R7: Opcode 3'd5 sets address 4'b1101 without any `sr_clk` edge. After one half period it captures `sr_out` into `pat_bit` and pulses `pat_valid`.
- R8: While `sampling` is high, `sr_clk`, `sr_addr`, `sr_in` and `rd_load` do not change. The interrupted command completes correctly afterwards.
- R9: A command presented while `busy` or `sampling` is high is ignored.
- R10: `sr_clk` stays high, and stays low, for max(`half_div`, 2) system clocks, so one serial clock is never shorter than 4 system clocks.
- R11: `busy` rises on the clock after a command is accepted. For loads and readouts it falls one system clock after the last falling edge of `sr_clk`.
- R12: Opcodes 3'd0, 3'd6 and 3'd7 start nothing: `busy` stays low and no `sr_clk` edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request pulse |
| cmd_op | input | 3 | Opcode |
| cmd_data | input | 8 | Word for opcodes 1 and 2 |
| half_div | input | DIV_W | System clocks per `sr_clk` half period (minimum 2 applied) |
| sampling | input | 1 | Sampler recording; freezes the serial pins |
| sr_out | input | 1 | Serial data from the sampler |
| sr_clk | output | 1 | Serial clock to the sampler |
| sr_in | output | 1 | Serial data to the sampler |
| sr_addr | output | 4 | Register select code |
| rd_load | output | 1 | Read-shift load strobe |
| busy | output | 1 | Command in progress |
| stop_pos | output | CELL_W | Fetched stop cell |
| stop_valid | output | 1 | One-clock pulse when `stop_pos` is updated |
| cell_idx | output | CELL_W | Physical cell for the ADC stage |
| cell_strobe | output | 1 | One pulse per cell step |
| pat_bit | output | 1 | Read-back write-pattern state |
| pat_valid | output | 1 | One-clock pulse when `pat_bit` is updated |

## Verification
The readout is run twice: once with a small stop cell, and once with a stop cell of 1020, so the index has to wrap from 1023 to 0. A design that counts from zero, or that never wraps, produces a run of wrong `cell_idx` values. The second readout is also paused by `sampling` in the middle of the cell phase, and a load is paused the same way. A design that keeps clocking, or that consumes a falling edge while frozen, shows pin changes during the pause and produces a shifted word or a wrong cell count. The bench measures the high time of `sr_clk` for divider values 3 and 1. A missing clamp would give a one-clock high phase. A second command is issued while a load is running, and the bench checks that the pattern register is left untouched and that exactly 8 edges occur.

// File: rtl/smp_ser_pkg.sv
package smp_ser_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_CFG   = 3'd1,
    OP_PAT   = 3'd2,
    OP_CHAIN = 3'd3,
    OP_READ  = 3'd4,
    OP_PATQ  = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_LDP,
    S_STOP,
    S_CELL,
    S_QPAT
  } st_e;

  localparam logic [3:0] A_IDLE = 4'b0000;
  localparam logic [3:0] A_CFG  = 4'b1100;
  localparam logic [3:0] A_PAT  = 4'b1101;
  localparam logic [3:0] A_RSR  = 4'b1011;

  localparam logic [7:0] CHAIN_CFG = 8'hFF;
  localparam logic [7:0] CHAIN_PAT = 8'h55;

endpackage

// File: rtl/smp_sclk_gen.sv
module smp_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  logic             run,
  input  logic             hold,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk,
  output logic             tick,
  output logic             fall_ev
);

  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

  logic [DIV_W-1:0] half_eff;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             fall_q, fall_d;
  logic             step;

  always_comb begin
    half_eff = (half_div < MIN_HALF) ? MIN_HALF : half_div;
    step     = act & ~hold;
    tick     = step & (cnt_q >= half_eff - 1'b1);
    cnt_d    = cnt_q;
    if (!act)      cnt_d = '0;
    else if (step) cnt_d = tick ? '0 : cnt_q + 1'b1;
    sclk_d = sclk_q;
    if (tick && run) sclk_d = ~sclk_q;
    // a falling edge seen just before a hold stays pending until release
    fall_d = hold ? fall_q : (tick & run & sclk_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
      fall_q <= fall_d;
    end
  end

  assign sclk    = sclk_q;
  assign fall_ev = fall_q & ~hold;

  // R8
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) |-> $stable(sclk_q));
  // R10
  sclk_hi_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |=> sclk_q);
  // R10
  sclk_lo_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_q) |=> !sclk_q);

endmodule

// File: rtl/smp_shift_unit.sv
module smp_shift_unit #(
  parameter int TX_W = 8,
  parameter int RX_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TX_W-1:0] load_val,
  input  logic            shift,
  input  logic            rx_en,
  input  logic            rx_bit,
  output logic            tx_bit,
  output logic [RX_W-1:0] rx_next
);

  logic [TX_W-1:0] tx_q, tx_d;
  logic [RX_W-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load)       tx_d = load_val;
    else if (shift) tx_d = {tx_q[TX_W-2:0], 1'b0};
    rx_next = {rx_q[RX_W-2:0], rx_bit};
    rx_d    = rx_q;
    if (shift && rx_en) rx_d = rx_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign tx_bit = tx_q[TX_W-1];

endmodule

// File: rtl/smp_ser_seq.sv
module smp_ser_seq
  import smp_ser_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int REG_W  = 8,
  parameter int NCELLS = 1024,
  localparam int CELL_W = $clog2(NCELLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [REG_W-1:0]  cmd_data,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              sampling,
  input  logic              sr_out,
  output logic              sr_clk,
  output logic              sr_in,
  output logic [3:0]        sr_addr,
  output logic              rd_load,
  output logic              busy,
  output logic [CELL_W-1:0] stop_pos,
  output logic              stop_valid,
  output logic [CELL_W-1:0] cell_idx,
  output logic              cell_strobe,
  output logic              pat_bit,
  output logic              pat_valid
);

  localparam logic [CELL_W-1:0] LAST_REG  = CELL_W'(REG_W - 1);
  localparam logic [CELL_W-1:0] LAST_STOP = CELL_W'(CELL_W - 1);
  localparam logic [CELL_W-1:0] LAST_CELL = CELL_W'(NCELLS - 1);

  // asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  st_e               st_q, st_d;
  logic              chain_q, chain_d;
  logic [CELL_W-1:0] bcnt_q, bcnt_d;
  logic [3:0]        addr_q, addr_d;
  logic [CELL_W-1:0] stop_q, stop_d, cur_q, cur_d, cidx_q, cidx_d;
  logic              cstb_q, cstb_d, svld_q, svld_d, pbit_q, pbit_d, pvld_q, pvld_d;
  logic              tx_load;
  logic [REG_W-1:0]  tx_val;
  logic              act, run, tick, fall_ev, tx_bit, accept;
  logic [CELL_W-1:0] rx_next;

  assign act    = (st_q != S_IDLE);
  assign run    = (st_q == S_LOAD) || (st_q == S_STOP) || (st_q == S_CELL);
  assign accept = cmd_valid && !act && !sampling;

  smp_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk(clk), .rst_n(rst_s_n), .act(act), .run(run), .hold(sampling),
    .half_div(half_div), .sclk(sr_clk), .tick(tick), .fall_ev(fall_ev)
  );

  smp_shift_unit #(.TX_W(REG_W), .RX_W(CELL_W)) u_shift (
    .clk(clk), .rst_n(rst_s_n), .load(tx_load), .load_val(tx_val),
    .shift(fall_ev), .rx_en(st_q == S_STOP), .rx_bit(sr_out),
    .tx_bit(tx_bit), .rx_next(rx_next)
  );

  always_comb begin
    st_d    = st_q;
    chain_d = chain_q;
    bcnt_d  = bcnt_q;
    addr_d  = addr_q;
    stop_d  = stop_q;
    cur_d   = cur_q;
    cidx_d  = cidx_q;
    pbit_d  = pbit_q;
    cstb_d  = 1'b0;
    svld_d  = 1'b0;
    pvld_d  = 1'b0;
    tx_load = 1'b0;
    tx_val  = cmd_data;
    unique case (st_q)
      S_IDLE: begin
        if (accept) begin
          bcnt_d = '0;
          unique case (cmd_op)
            OP_CFG:   begin st_d = S_LOAD; addr_d = A_CFG; tx_load = 1'b1; chain_d = 1'b0; end
            OP_PAT:   begin st_d = S_LOAD; addr_d = A_PAT; tx_load = 1'b1; chain_d = 1'b0; end
            OP_CHAIN: begin st_d = S_LOAD; addr_d = A_CFG; tx_load = 1'b1; tx_val = CHAIN_CFG; chain_d = 1'b1; end
            OP_READ:  begin st_d = S_LDP;  addr_d = A_RSR; end
            OP_PATQ:  begin st_d = S_QPAT; addr_d = A_PAT; end
            default:  ;
          endcase
        end
      end
      S_LOAD: begin
        if (fall_ev) begin
          if (bcnt_q == LAST_REG) begin
            bcnt_d = '0;
            if (chain_q) begin
              chain_d = 1'b0;
              addr_d  = A_PAT;
              tx_load = 1'b1;
              tx_val  = CHAIN_PAT;
            end else begin
              st_d   = S_IDLE;
              addr_d = A_IDLE;
            end
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
      end
      S_LDP: begin
        if (tick) st_d = S_STOP;
      end
      S_STOP: begin
        if (fall_ev) begin
          if (bcnt_q == LAST_STOP) begin
            bcnt_d = '0;
            stop_d = rx_next;
            cur_d  = rx_next;
            svld_d = 1'b1;
            st_d   = S_CELL;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
      end
      S_CELL: begin
        if (fall_ev) begin
          cstb_d = 1'b1;
          cidx_d = cur_q;
          cur_d  = (cur_q == LAST_CELL) ? '0 : cur_q + 1'b1;
          if (bcnt_q == LAST_CELL) begin
            bcnt_d = '0;
            st_d   = S_IDLE;
            addr_d = A_IDLE;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
      end
      S_QPAT: begin
        if (tick) begin
          pbit_d = sr_out;
          pvld_d = 1'b1;
          st_d   = S_IDLE;
          addr_d = A_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q    <= S_IDLE;
      chain_q <= 1'b0;
      bcnt_q  <= '0;
      addr_q  <= A_IDLE;
      stop_q  <= '0;
      cur_q   <= '0;
      cidx_q  <= '0;
      cstb_q  <= 1'b0;
      svld_q  <= 1'b0;
      pbit_q  <= 1'b0;
      pvld_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      chain_q <= chain_d;
      bcnt_q  <= bcnt_d;
      addr_q  <= addr_d;
      stop_q  <= stop_d;
      cur_q   <= cur_d;
      cidx_q  <= cidx_d;
      cstb_q  <= cstb_d;
      svld_q  <= svld_d;
      pbit_q  <= pbit_d;
      pvld_q  <= pvld_d;
    end
  end

  assign sr_in       = (st_q == S_LOAD) & tx_bit;
  assign sr_addr     = addr_q;
  assign rd_load     = (st_q == S_LDP);
  assign busy        = act;
  assign stop_pos    = stop_q;
  assign stop_valid  = svld_q;
  assign cell_idx    = cidx_q;
  assign cell_strobe = cstb_q;
  assign pat_bit     = pbit_q;
  assign pat_valid   = pvld_q;

  // R1 R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !busy |-> (!sr_clk && !rd_load && !sr_in));
  // R5
  load_strobe_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    rd_load |-> (sr_addr == A_RSR && !sr_clk));
  // R8
  freeze_pins_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $past(sampling) |-> ($stable(sr_addr) && $stable(sr_in) && $stable(rd_load)));
  // R9
  no_start_sampling_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!busy && sampling) |=> !busy);
  // R6
  cell_in_cmd_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    cell_strobe |-> $past(busy));

endmodule

// File: tb/test_smp_ser_seq.sv
`timescale 1ns/1ps
module test_smp_ser_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_data = 8'h00;
  logic [7:0] half_div = 8'd2;
  logic       sampling = 1'b0;
  logic       sr_out;
  logic       sr_clk, sr_in, rd_load, busy, stop_valid, cell_strobe, pat_bit, pat_valid;
  logic [3:0] sr_addr;
  logic [9:0] stop_pos, cell_idx;

  always #2.5 clk = ~clk;

  smp_ser_seq i_smp_ser_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .half_div(half_div), .sampling(sampling),
    .sr_out(sr_out), .sr_clk(sr_clk), .sr_in(sr_in), .sr_addr(sr_addr),
    .rd_load(rd_load), .busy(busy), .stop_pos(stop_pos), .stop_valid(stop_valid),
    .cell_idx(cell_idx), .cell_strobe(cell_strobe), .pat_bit(pat_bit),
    .pat_valid(pat_valid)
  );

  int nchk = 0, nerr = 0, cyc = 0;

  // sampler model and observers
  logic [7:0] m_cfg = 8'h00, m_pat = 8'h00;
  logic [9:0] stop_val = 10'd0;
  logic       rsr_bit = 1'b0, pat_state = 1'b0, samp_q = 1'b0;
  logic       p_clk = 1'b0, p_in = 1'b0, p_ld = 1'b0, p_busy = 1'b0;
  logic [3:0] p_addr = 4'b0000;
  int rptr = 0, falls = 0, last_fall = 0, rise_cyc = 0, hi_w = 0, busy_drop = 0;
  int frz_viol = 0, ld_viol = 0, ncell = 0, cell_bad = 0, nstop = 0, npat = 0;
  int exp_start = 0, got_stop = 0, got_pat = 0;

  assign sr_out = (sr_addr == 4'b1101) ? pat_state : rsr_bit;

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    samp_q <= sampling;
  end

  always @(negedge clk) begin
    if (samp_q && (sr_clk !== p_clk || sr_addr !== p_addr || sr_in !== p_in || rd_load !== p_ld))
      frz_viol++;
    if (rd_load && (sr_addr != 4'b1011 || sr_clk)) ld_viol++;
    if (rd_load) rptr = 0;
    if (sr_clk && !p_clk) rise_cyc = cyc;
    if (!sr_clk && p_clk) begin
      falls++;
      last_fall = cyc;
      hi_w = cyc - rise_cyc;
      case (sr_addr)
        4'b1100: m_cfg = {m_cfg[6:0], sr_in};
        4'b1101: m_pat = {m_pat[6:0], sr_in};
        4'b1011: begin
          rsr_bit = (rptr < 10) ? stop_val[9 - rptr] : 1'b0;
          rptr++;
        end
        default: ;
      endcase
    end
    if (p_busy && !busy) busy_drop = cyc;
    if (cell_strobe) begin
      if (int'(cell_idx) != (exp_start + ncell) % 1024) cell_bad++;
      ncell++;
    end
    if (stop_valid) begin got_stop = int'(stop_pos); nstop++; end
    if (pat_valid)  begin got_pat = int'(pat_bit); npat++; end
    p_clk = sr_clk; p_addr = sr_addr; p_in = sr_in; p_ld = rd_load; p_busy = busy;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  always @(posedge clk) if (cyc == 150000) begin
    nchk++; nerr++;
    $display("FAIL watchdog R11 run did not finish actual=%0d expected<150000", cyc);
    summary();
    $finish;
  end

  task automatic idle_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    idle_wait(3);
  endtask

  task automatic clr();
    falls = 0; ncell = 0; cell_bad = 0; nstop = 0; npat = 0; frz_viol = 0; ld_viol = 0;
  endtask

  task automatic t_reset();
    idle_wait(4);
    chk("R1 sr_clk after reset", sr_clk, 0);
    chk("R1 busy after reset", busy, 0);
    chk("R1 rd_load after reset", rd_load, 0);
    chk("R1 sr_addr after reset", sr_addr, 0);
  endtask

  task automatic t_cfg();
    clr(); half_div = 8'd2;
    issue(3'd1, 8'hA6);
    chk("R11 busy after accept", busy, 1);
    wait_done();
    chk("R2 cfg word", m_cfg, 8'hA6);
    chk("R2 cfg edges", falls, 8);
    chk("R11 busy drop after last fall", busy_drop - last_fall, 1);
    chk("R10 high time div=2", hi_w, 2);
  endtask

  task automatic t_pat_div3();
    clr(); half_div = 8'd3;
    issue(3'd2, 8'h3C);
    wait_done();
    chk("R3 pattern word", m_pat, 8'h3C);
    chk("R3 pattern edges", falls, 8);
    chk("R10 high time div=3", hi_w, 3);
  endtask

  task automatic t_div_clamp();
    clr(); half_div = 8'd1;
    issue(3'd1, 8'h5A);
    wait_done();
    chk("R10 high time div=1 clamps to 2", hi_w, 2);
    chk("R2 cfg word at min period", m_cfg, 8'h5A);
    half_div = 8'd2;
  endtask

  task automatic t_chain();
    clr(); m_cfg = 8'h00; m_pat = 8'h00;
    issue(3'd3, 8'h00);
    wait_done();
    chk("R4 chain cfg", m_cfg, 8'hFF);
    chk("R4 chain pattern", m_pat, 8'h55);
    chk("R4 chain edges", falls, 16);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] pat_before;
    clr(); pat_before = m_pat;
    issue(3'd1, 8'h0F);
    idle_wait(5);
    issue(3'd2, 8'hAA);
    wait_done();
    chk("R9 cfg completes", m_cfg, 8'h0F);
    chk("R9 pattern untouched", m_pat, pat_before);
    chk("R9 only one load of edges", falls, 8);
  endtask

  task automatic t_bad_ops();
    clr();
    issue(3'd0, 8'hFF);
    chk("R12 op0 no busy", busy, 0);
    issue(3'd7, 8'hFF);
    chk("R12 op7 no busy", busy, 0);
    issue(3'd6, 8'hFF);
    idle_wait(20);
    chk("R12 no edges", falls, 0);
  endtask

  task automatic t_sampling_block();
    clr();
    @(negedge clk); sampling = 1'b1;
    issue(3'd1, 8'h11);
    chk("R9 no start while sampling", busy, 0);
    idle_wait(10);
    chk("R9 no edges while sampling", falls, 0);
    @(negedge clk); sampling = 1'b0;
    idle_wait(3);
  endtask

  task automatic t_pause_load();
    clr();
    issue(3'd1, 8'hC3);
    idle_wait(9);
    sampling = 1'b1;
    idle_wait(25);
    sampling = 1'b0;
    wait_done();
    chk("R8 pins frozen during load pause", frz_viol, 0);
    chk("R8 cfg after pause", m_cfg, 8'hC3);
    chk("R8 edges after pause", falls, 8);
  endtask

  task automatic t_patq();
    clr(); pat_state = 1'b1;
    issue(3'd5, 8'h00);
    wait_done();
    chk("R7 pattern state one", got_pat, 1);
    pat_state = 1'b0;
    issue(3'd5, 8'h00);
    wait_done();
    chk("R7 pattern state zero", got_pat, 0);
    chk("R7 two valid pulses", npat, 2);
    chk("R7 no serial edges", falls, 0);
  endtask

  task automatic t_readout(input int stopv, input bit pause);
    clr(); stop_val = 10'(stopv); exp_start = stopv;
    issue(3'd4, 8'h00);
    if (pause) begin
      idle_wait(2000);
      sampling = 1'b1;
      idle_wait(40);
      sampling = 1'b0;
    end
    wait_done();
    chk("R5 load strobe address and clock", ld_viol, 0);
    chk("R5 stop cell value", got_stop, stopv);
    chk("R5 one stop pulse", nstop, 1);
    chk("R6 cell count", ncell, 1024);
    chk("R6 cell index mismatches", cell_bad, 0);
    chk("R6 total edges", falls, 1034);
    if (pause) chk("R8 pins frozen in cell phase", frz_viol, 0);
  endtask

  initial begin
    idle_wait(3);
    rst_n = 1'b1;
    t_reset();
    t_cfg();
    t_pat_div3();
    t_div_clamp();
    t_chain();
    t_busy_ignore();
    t_bad_ops();
    t_sampling_block();
    t_pause_load();
    t_patq();
    t_readout(5, 1'b0);
    t_readout(1020, 1'b1);
    summary();
    $finish;
  end

endmodule